// File: doc/BRIEF.md
# LZSS Sliding-Window Stream Decompressor

This block expands a byte-serial LZSS stream in hardware. Compressed bytes enter through a valid/ready port that carries an end-of-stream marker on the final byte. Expanded bytes leave through a second valid/ready port. Each stream opens with an 8-byte signature and a 3-byte little-endian count of output bytes. After that come groups of tokens. Each group is led by a flag byte, and each token is either a literal byte or a two-byte back-reference into a 4096-byte history window.

The window is a local RAM. It is zeroed before every stream, and its write pointer starts at index 0xFEE. A back-reference is replayed one byte at a time, and each replayed byte is also written back into the window, so a copy that overlaps its own output makes a repeating run. When the requested number of bytes has been handed off, the block raises a one-cycle `done` pulse. A bad signature, or a stream that ends too early, raises a one-cycle `error` pulse instead. After either pulse, any remaining bytes up to the end-of-stream marker are discarded, and the block re-arms for the next stream.

Top module: `lzss_window_decoder`

## Requirements
- R1: Before a stream's first token, every window position reads as 0x00, so a back-reference into unwritten positions yields zero bytes.
- R2: The first byte a stream writes into the window lands at index 0xFEE, and each later write goes to the next index modulo 4096.
- R3: The first 8 input bytes must equal 53 4C 49 44 45 34 4B 00 in that order. The first mismatching byte causes a one-cycle `error` pulse, and no output byte is produced for that stream.
- R4: The 3 bytes after the signature give the output length, least significant byte first.
- R5: A flag byte is fetched before the first token and again after every 8 tokens. Its bits are used from bit 0 upward, and a 1 bit marks a literal: the next input byte is output and stored in the window.
- R6: A 0 flag bit marks a back-reference of two input bytes A then B. The source index is {B[7:4], A}, and the copy length is B[3:0] + 2.
- R7: A back-reference whose source overlaps the bytes it is producing repeats them, byte by byte.
- R8: Exactly the header's count of bytes is output, even if a copy is cut short. A one-cycle `done` pulse follows once the last byte has been accepted. A count of zero gives `done` with no output.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` holds its value. No byte is lost or repeated under backpressure.
- R10: If the byte marked `in_last` has been consumed and another input byte is still needed, `error` pulses once.
- R11: `in_ready` stays low while the window is being zeroed, which takes about 4096 cycles, and whenever a literal is pending but the output holding register is full.
- R12: After `done` or `error`, input bytes up to and including the one marked `in_last` are discarded. The window is then zeroed again, and the next stream is decoded on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Compressed byte present |
| in_ready | output | 1 | Decoder takes the byte this cycle |
| in_data | input | 8 | Compressed byte |
| in_last | input | 1 | Marks the final byte of a stream |
| out_valid | output | 1 | Expanded byte present |
| out_ready | input | 1 | Sink takes the byte this cycle |
| out_data | output | 8 | Expanded byte |
| done | output | 1 | One-cycle pulse: stream complete |
| error | output | 1 | One-cycle pulse: bad signature or early end |

## Verification
The decoder is driven with a set of streams, each isolating one effect:
- All literals check flag bit order and the little-endian length.
- A self-overlapping back-reference tells byte-serial replay apart from a block read.
- A copy from index 0 with a length larger than the count checks the zero fill and that output stops at the count.
- A nine-literal stream checks that a new flag byte is fetched after exactly eight tokens.
- A copy from 0xFEE placed right after a stream that wrote there shows the window is zeroed again.

Negative streams (a broken signature, a stream cut short, a zero count, trailing bytes after completion) check the pulses and the discard behaviour. All of this runs with gaps on the input and a periodic `out_ready` drop, and one run holds the output stalled to confirm the byte is held steady and the input is throttled.

// File: rtl/lzd_pkg.sv
package lzd_pkg;
   typedef enum logic [3:0] {
      ST_CLEAR,
      ST_MAGIC,
      ST_SIZE,
      ST_NEXT,
      ST_FLAG,
      ST_TOKEN,
      ST_REF2,
      ST_COPY,
      ST_FIN,
      ST_DRAIN
   } lzd_state_e;
endpackage

// File: rtl/lzd_window_ram.sv
module lzd_window_ram #(
   parameter int unsigned AW = 12,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // asynchronous read: a byte written on one edge is visible the next cycle
   assign rdata = mem[raddr];
endmodule

// File: rtl/lzd_magic_match.sv
module lzd_magic_match #(
   parameter int unsigned           LEN     = 8,
   parameter int unsigned           IDX_W   = 3,
   parameter logic [8*LEN-1:0]      PATTERN = 64'h534C_4944_4534_4B00
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       byte_in,
   output logic             hit
);
   logic [7:0] exp_b [LEN];

   // first stream byte sits in the most significant byte of PATTERN
   for (genvar g = 0; g < LEN; g++) begin : g_byte
      assign exp_b[g] = PATTERN[8*(LEN-1-g) +: 8];
   end

   assign hit = (byte_in == exp_b[idx]);
endmodule

// File: rtl/lzd_out_stage.sv
module lzd_out_stage #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] din,
   output logic          space,
   input  logic          out_ready,
   output logic          out_valid,
   output logic [DW-1:0] out_data
);
   assign space = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_data  <= din;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   assert_load_space_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (!out_valid || out_ready));
endmodule

// File: rtl/lzss_window_decoder.sv
module lzss_window_decoder
   import lzd_pkg::*;
#(
   parameter int unsigned                WIN_AW     = 12,
   parameter int unsigned                INIT_POS   = 'hFEE,
   parameter int unsigned                MAGIC_LEN  = 8,
   parameter logic [8*MAGIC_LEN-1:0]     MAGIC      = 64'h534C_4944_4534_4B00,
   parameter int unsigned                SIZE_BYTES = 3,
   parameter int unsigned                LEN_BITS   = 4,
   parameter int unsigned                LEN_BIAS   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic [7:0] in_data,
   input  logic       in_last,
   output logic       out_valid,
   input  logic       out_ready,
   output logic [7:0] out_data,
   output logic       done,
   output logic       error
);
   localparam int unsigned CNT_W  = 8 * SIZE_BYTES;
   localparam int unsigned HIDX_W = $clog2(MAGIC_LEN);
   localparam int unsigned CPY_W  = LEN_BITS + 1;

   initial begin
      assert (WIN_AW == 16 - LEN_BITS) else $error("offset fields must span the window");
      assert (SIZE_BYTES >= 2 && SIZE_BYTES <= MAGIC_LEN) else $error("size field width");
      assert (INIT_POS < (1 << WIN_AW)) else $error("start index outside window");
      assert ((1 << LEN_BITS) - 1 + LEN_BIAS < (1 << CPY_W)) else $error("copy counter width");
   end

   lzd_state_e        state_q;
   logic [WIN_AW-1:0] clr_q, wpos_q, rpos_q;
   logic [CNT_W-1:0]  size_q, cnt_q;
   logic [CPY_W-1:0]  len_q;
   logic [HIDX_W-1:0] hidx_q;
   logic [15:0]       flags_q;
   logic [7:0]        lo_q;
   logic              eos_q, done_q, err_q;

   logic              space, need_in, take, magic_hit;
   logic              lit_emit, cpy_emit, win_we;
   logic [WIN_AW-1:0] win_waddr;
   logic [7:0]        win_wdata, win_rdata, emit_byte;
   logic [15:0]       flags_sh;

   assign flags_sh = {1'b0, flags_q[15:1]};

   always_comb begin
      case (state_q)
         ST_MAGIC, ST_SIZE, ST_FLAG, ST_REF2, ST_DRAIN: need_in = 1'b1;
         ST_TOKEN: need_in = !flags_q[0] || space;
         default:  need_in = 1'b0;
      endcase
   end

   assign in_ready  = need_in && !eos_q;
   assign take      = in_valid && in_ready;
   assign lit_emit  = (state_q == ST_TOKEN) && flags_q[0] && take;
   assign cpy_emit  = (state_q == ST_COPY) && space;
   assign emit_byte = lit_emit ? in_data : win_rdata;
   assign win_we    = (state_q == ST_CLEAR) || lit_emit || cpy_emit;
   assign win_waddr = (state_q == ST_CLEAR) ? clr_q : wpos_q;
   assign win_wdata = (state_q == ST_CLEAR) ? 8'h00 : emit_byte;

   lzd_window_ram #(.AW(WIN_AW), .DW(8)) u_win (
      .clk   (clk),
      .we    (win_we),
      .waddr (win_waddr),
      .wdata (win_wdata),
      .raddr (rpos_q),
      .rdata (win_rdata)
   );

   lzd_magic_match #(.LEN(MAGIC_LEN), .IDX_W(HIDX_W), .PATTERN(MAGIC)) u_magic (
      .idx     (hidx_q),
      .byte_in (in_data),
      .hit     (magic_hit)
   );

   lzd_out_stage #(.DW(8)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (lit_emit || cpy_emit),
      .din       (emit_byte),
      .space     (space),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                     eos_q <= 1'b0;
      else if (state_q == ST_CLEAR)   eos_q <= 1'b0;
      else if (take && in_last)       eos_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_CLEAR;
         clr_q   <= '0;
         wpos_q  <= '0;
         rpos_q  <= '0;
         size_q  <= '0;
         cnt_q   <= '0;
         len_q   <= '0;
         hidx_q  <= '0;
         flags_q <= '0;
         lo_q    <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state_q)
            ST_CLEAR: begin
               clr_q <= clr_q + 1'b1;
               if (&clr_q) begin
                  state_q <= ST_MAGIC;
                  wpos_q  <= WIN_AW'(INIT_POS);
                  cnt_q   <= '0;
                  size_q  <= '0;
                  flags_q <= '0;
                  hidx_q  <= '0;
               end
            end
            ST_MAGIC: begin
               if (eos_q) begin
                  err_q <= 1'b1;  state_q <= ST_DRAIN;
               end else if (take) begin
                  if (!magic_hit) begin
                     err_q <= 1'b1;  state_q <= ST_DRAIN;
                  end else if (hidx_q == HIDX_W'(MAGIC_LEN - 1)) begin
                     hidx_q <= '0;  state_q <= ST_SIZE;
                  end else begin
                     hidx_q <= hidx_q + 1'b1;
                  end
               end
            end
            ST_SIZE: begin
               if (eos_q) begin
                  err_q <= 1'b1;  state_q <= ST_DRAIN;
               end else if (take) begin
                  size_q <= {in_data, size_q[CNT_W-1:8]};
                  if (hidx_q == HIDX_W'(SIZE_BYTES - 1)) state_q <= ST_NEXT;
                  else                                   hidx_q  <= hidx_q + 1'b1;
               end
            end
            ST_NEXT: begin
               if (cnt_q == size_q)   state_q <= ST_FIN;
               else if (!flags_sh[8]) state_q <= ST_FLAG;
               else begin
                  flags_q <= flags_sh;  state_q <= ST_TOKEN;
               end
            end
            ST_FLAG: begin
               if (eos_q) begin
                  err_q <= 1'b1;  state_q <= ST_DRAIN;
               end else if (take) begin
                  flags_q <= {8'hFF, in_data};  state_q <= ST_TOKEN;
               end
            end
            ST_TOKEN: begin
               if (eos_q) begin
                  err_q <= 1'b1;  state_q <= ST_DRAIN;
               end else if (take) begin
                  if (flags_q[0]) begin
                     wpos_q  <= wpos_q + 1'b1;
                     cnt_q   <= cnt_q + 1'b1;
                     state_q <= ST_NEXT;
                  end else begin
                     lo_q    <= in_data;
                     state_q <= ST_REF2;
                  end
               end
            end
            ST_REF2: begin
               if (eos_q) begin
                  err_q <= 1'b1;  state_q <= ST_DRAIN;
               end else if (take) begin
                  rpos_q  <= {in_data[7:LEN_BITS], lo_q};
                  len_q   <= CPY_W'(in_data[LEN_BITS-1:0]) + CPY_W'(LEN_BIAS);
                  state_q <= ST_COPY;
               end
            end
            ST_COPY: begin
               if (space) begin
                  wpos_q <= wpos_q + 1'b1;
                  rpos_q <= rpos_q + 1'b1;
                  cnt_q  <= cnt_q + 1'b1;
                  len_q  <= len_q - 1'b1;
                  if (len_q == CPY_W'(1) || (cnt_q + CNT_W'(1)) == size_q) state_q <= ST_NEXT;
               end
            end
            ST_FIN: begin
               if (!out_valid) begin
                  done_q <= 1'b1;  state_q <= ST_DRAIN;
               end
            end
            ST_DRAIN: begin
               if (eos_q) begin
                  clr_q <= '0;  state_q <= ST_CLEAR;
               end
            end
            default: state_q <= ST_CLEAR;
         endcase
      end
   end

   assign done  = done_q;
   assign error = err_q;

   assert_hdr_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      state_q inside {ST_MAGIC, ST_SIZE} |-> !out_valid);

   assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      state_q inside {ST_NEXT, ST_FLAG, ST_TOKEN, ST_REF2, ST_COPY, ST_FIN} |-> cnt_q <= size_q);

   assert_sentinel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_TOKEN |-> flags_q[8]);

   assert_copy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_COPY |-> (len_q >= CPY_W'(1)) &&
                             (len_q <= CPY_W'((1 << LEN_BITS) - 1 + LEN_BIAS)));

   assert_clear_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_CLEAR |-> !in_ready && !out_valid);

   assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !err_q && !out_valid);
endmodule

// File: tb/sim_lzss_window_decoder.sv
module sim_lzss_window_decoder;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 10;
   localparam logic [63:0] HDR = 64'h534C_4944_4534_4B00;

   typedef struct packed {
      int           n_in;
      logic [191:0] din;
      int           n_out;
      logic [191:0] dout;
      logic         err;
   } vec_t;

   // bytes are right-aligned: stream byte i sits at [8*(n-1-i) +: 8]
   localparam vec_t VECS [NV] = '{
      '{15, 192'({HDR, 8'h03, 8'h00, 8'h00, 8'h07, 8'h41, 8'h42, 8'h43}),
        3,  192'({8'h41, 8'h42, 8'h43}), 1'b0},
      '{15, 192'({HDR, 8'h06, 8'h00, 8'h00, 8'h01, 8'h58, 8'hEE, 8'hF3}),
        6,  192'({6{8'h58}}), 1'b0},
      '{14, 192'({HDR, 8'h02, 8'h00, 8'h00, 8'h00, 8'hEE, 8'hF0}),
        2,  192'(16'h0000), 1'b0},
      '{14, 192'({HDR, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h03}),
        3,  192'(24'h000000), 1'b0},
      '{22, 192'({HDR, 8'h09, 8'h00, 8'h00, 8'hFF, 8'h01, 8'h02, 8'h03, 8'h04,
                  8'h05, 8'h06, 8'h07, 8'h08, 8'h01, 8'h09}),
        9,  192'({8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09}), 1'b0},
      '{16, 192'({HDR, 8'h05, 8'h00, 8'h00, 8'h03, 8'h61, 8'h62, 8'hEE, 8'hF1}),
        5,  192'({8'h61, 8'h62, 8'h61, 8'h62, 8'h61}), 1'b0},
      '{4,  192'({8'h53, 8'h4C, 8'h49, 8'h00}),
        0,  192'(0), 1'b1},
      '{14, 192'({HDR, 8'h04, 8'h00, 8'h00, 8'h0F, 8'h01, 8'h02}),
        2,  192'({8'h01, 8'h02}), 1'b1},
      '{11, 192'({HDR, 8'h00, 8'h00, 8'h00}),
        0,  192'(0), 1'b0},
      '{15, 192'({HDR, 8'h01, 8'h00, 8'h00, 8'h01, 8'h77, 8'h99, 8'h99}),
        1,  192'(8'h77), 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = 8'h00;
   logic       in_last = 1'b0;
   logic       out_valid;
   logic       out_ready = 1'b0;
   logic [7:0] out_data;
   logic       done;
   logic       error;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lzss_window_decoder u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .in_last   (in_last),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .done      (done),
      .error     (error)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         checks = checks + 1;
         errors = errors + 1;
         $display("FAIL R11 watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic string vec_req(input int v);
      case (v)
         0: return "R4/R5";
         1: return "R7/R2";
         2: return "R12";
         3: return "R1/R8";
         4: return "R5";
         5: return "R6";
         6: return "R3";
         7: return "R10";
         8: return "R8";
         default: return "R12";
      endcase
   endfunction

   task automatic run_vec(input int v, input bit stall);
      vec_t       t = VECS[v];
      int         idx = 0;
      int         got = 0;
      int         cyc = 0;
      int         stall_left = 25;
      bit         saw_done = 0;
      bit         saw_err = 0;
      bit         fin = 0;
      bit         seen = 0;
      bit         stall_ok = 1;
      logic [7:0] first = 8'h00;
      string      req = stall ? "R9/R11" : vec_req(v);
      while (!fin) begin
         @(negedge clk);
         in_valid  = (idx < t.n_in) && (cyc % 5 != 4);
         in_data   = in_valid ? t.din[8*(t.n_in-1-idx) +: 8] : 8'h00;
         in_last   = in_valid && (idx == t.n_in - 1);
         out_ready = (cyc % 3 != 2);
         if (stall && stall_left > 0) out_ready = 1'b0;
         #1;
         if (stall && seen && stall_left > 0) begin
            if (!out_valid || out_data !== first || in_ready) stall_ok = 0;
            stall_left--;
         end
         if (in_valid && in_ready) idx++;
         if (out_valid && !seen) begin
            seen  = 1;
            first = out_data;
         end
         if (out_valid && out_ready) begin
            if (got < t.n_out)
               chk(out_data == t.dout[8*(t.n_out-1-got) +: 8], req, "output byte",
                   int'(out_data), int'(t.dout[8*(t.n_out-1-got) +: 8]));
            else
               chk(1'b0, req, "extra output byte", int'(out_data), -1);
            got++;
         end
         if (done)  saw_done = 1;
         if (error) saw_err  = 1;
         cyc++;
         if ((saw_done || saw_err) && idx == t.n_in) fin = 1;
         if (cyc > 12000) begin
            chk(1'b0, req, "stream timeout", cyc, 12000);
            fin = 1;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      chk(got == t.n_out, req, "output byte count", got, t.n_out);
      chk(saw_err == t.err, req, "error pulse", int'(saw_err), int'(t.err));
      chk(saw_done == !t.err, req, "done pulse", int'(saw_done), int'(!t.err));
      if (stall) chk(stall_ok, "R9", "held byte and throttled input", int'(stall_ok), 1);
   endtask

   initial begin
      int low_cnt;
      repeat (3) @(negedge clk);
      #1;
      chk(!out_valid, "R9", "reset out_valid", int'(out_valid), 0);
      chk(!in_ready, "R11", "reset in_ready", int'(in_ready), 0);
      chk(!done, "R8", "reset done", int'(done), 0);
      chk(!error, "R10", "reset error", int'(error), 0);

      // zeroing period: in_ready low for one sample per clear write
      @(negedge clk);
      rst_n = 1'b1;
      low_cnt = 0;
      #1;
      while (!in_ready && low_cnt < 6000) begin
         low_cnt++;
         @(negedge clk);
         #1;
      end
      chk(low_cnt >= 4090 && low_cnt <= 4100, "R11", "clear stall length", low_cnt, 4096);

      // table of streams
      for (int v = 0; v < NV; v++) run_vec(v, 1'b0);

      // directed: long output stall on the literal stream
      run_vec(0, 1'b1);

      // directed: stream right after a stall run decodes cleanly again
      run_vec(3, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule